// File: doc/BRIEF.md
# SAR Converter Sequencing Controller

This block is the digital sequencer that sits beside a successive-approximation converter core. It runs the converter through three states: a held reset, an acquisition (tracking) phase and a timed conversion phase. A host starts each conversion with a rising edge on a start pin. The block times the conversion with a cycle counter of programmable length, then captures the result word and returns to acquisition.

Every host-side pin is asynchronous to the block clock. Each one passes through a two-stage synchronizer before any edge or level is acted on. A ready output tells the host when the converter is idle, and it does so only while the chip-select pin is deasserted. The converter result is modelled as a parallel word presented on an input port.

Leaving the held reset is conditional. At the moment the device reset pin is released, the start and serial-clock pins must be low and chip select must be high. If any of them is not, the controller stays in reset until the reset pin is pulsed again.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While the synchronized device reset pin `dev_rst_n` is low, the state is reset, `rdy` and `conv_busy_n` are low, and `conv_done` stays low.
- R2: When `dev_rst_n` rises while `conv_start` is low, `sclk` is low and `cs_n` is high, the block enters acquisition and `rdy` goes high. This happens EXIT_CYC + 3 clock cycles after the pin edge.
- R3: If any of those three pins is at the wrong level when `dev_rst_n` rises, the block stays in reset indefinitely. Correcting the pins afterwards has no effect. Only a new low pulse on `dev_rst_n` allows another exit attempt.
- R4: A rising edge on `conv_start` during acquisition starts a conversion. `conv_busy_n` falls 3 clock cycles after the pin edge. A conversion is only ever entered from acquisition.
- R5: A conversion lasts `conv_len` clock cycles, clamped to the range CONV_MIN..CONV_MAX. `conv_busy_n` is low for exactly that many cycles.
- R6: Edges on `conv_start` during a conversion are ignored. They neither lengthen the running conversion nor start another one afterwards.
- R7: At the end of a conversion, `conv_busy_n` returns high and `conv_done` pulses for exactly one cycle. In that same cycle `sample_out` shows the `sample_in` value present at the end of the conversion.
- R8: While `cs_n` is high, `rdy` equals `conv_busy_n`. While `cs_n` is low, `rdy` is low and `conv_busy_n` is unaffected. A change on `cs_n` reaches `rdy` after 3 cycles.
- R9: A low level on `dev_rst_n` during a conversion aborts it into reset. No `conv_done` pulse is given and `sample_out` keeps its previous value.
- R10: `ctrl_state` encodes the state as reset = 2'b00, acquisition = 2'b01 and conversion = 2'b10. The value 2'b11 never appears.
- R11: The fabric reset `rst` (synchronous, active high) puts the block in the reset state with all outputs low and `sample_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (internal conversion timing clock) |
| rst | input | 1 | Synchronous active-high fabric reset |
| dev_rst_n | input | 1 | Asynchronous active-low device reset pin |
| conv_start | input | 1 | Asynchronous conversion start pin, rising edge active |
| cs_n | input | 1 | Asynchronous active-low chip select pin |
| sclk | input | 1 | Asynchronous serial clock pin (checked on reset exit) |
| conv_len | input | LEN_W | Requested conversion length in clock cycles |
| sample_in | input | DATA_W | Converter result word, modelled |
| rdy | output | 1 | Ready indication toward the host |
| conv_busy_n | output | 1 | Conversion status: high when idle in acquisition |
| conv_done | output | 1 | One-cycle pulse at the end of each conversion |
| ctrl_state | output | 2 | Current state code |
| sample_out | output | DATA_W | Result word captured at the end of the last conversion |

## Verification
Conversions are run with requested lengths that are in range, below the minimum and above the maximum. Each is paired with a distinct result word, so that clamping errors and wrong capture timing show up separately. Start pulses injected in the middle of a conversion distinguish a controller that truly ignores them from one that restarts or queues a conversion. Reset releases with chip select low or with the serial clock high are checked against a clean release. Among other faults, this catches a controller that re-checks pin levels after release instead of only at the release edge. A reset during a conversion is used to tell an abort apart from an early completion.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_RST  = 2'b00,
    ST_ACQ  = 2'b01,
    ST_CONV = 2'b10
  } ctrl_state_e;

  // Bit positions inside the synchronized pin bundle
  localparam int PIN_RSTN  = 0;
  localparam int PIN_START = 1;
  localparam int PIN_CSN   = 2;
  localparam int PIN_SCLK  = 3;
  localparam int PIN_NUM   = 4;

  function automatic int clamp_len(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);

  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/adc_down_timer.sv
module adc_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_n_s,
  input  logic        rst_rise,
  input  logic        start_rise,
  input  logic        pins_ok,
  input  logic        exit_expired,
  input  logic        conv_expired,
  output ctrl_state_e state_q,
  output ctrl_state_e state_d,
  output logic        exit_load,
  output logic        conv_load
);

  logic armed_q, armed_d;

  always_comb begin
    state_d   = state_q;
    armed_d   = armed_q;
    exit_load = 1'b0;
    conv_load = 1'b0;
    if (!rst_n_s) begin
      state_d = ST_RST;
      armed_d = 1'b0;
    end else begin
      case (state_q)
        ST_RST: begin
          if (rst_rise) begin
            // pin levels are judged only at the release edge
            armed_d   = pins_ok;
            exit_load = pins_ok;
          end else if (armed_q && exit_expired) begin
            state_d = ST_ACQ;
            armed_d = 1'b0;
          end
        end
        ST_ACQ: begin
          if (start_rise) begin
            state_d   = ST_CONV;
            conv_load = 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_expired) state_d = ST_ACQ;
        end
        default: state_d = ST_RST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RST;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_MIN    = 60,
  parameter int CONV_MAX    = 68,
  parameter int EXIT_CYC    = 250000,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(CONV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst_n,
  input  logic              conv_start,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [LEN_W-1:0]  conv_len,
  input  logic [DATA_W-1:0] sample_in,
  output logic              rdy,
  output logic              conv_busy_n,
  output logic              conv_done,
  output logic [1:0]        ctrl_state,
  output logic [DATA_W-1:0] sample_out
);

  localparam int EXIT_W = (EXIT_CYC < 2) ? 1 : $clog2(EXIT_CYC);
  localparam logic [EXIT_W-1:0] EXIT_LOAD = EXIT_W'(EXIT_CYC - 1);
  localparam logic [PIN_NUM-1:0] PIN_RST_VAL = PIN_NUM'(1) << PIN_CSN;

  logic [PIN_NUM-1:0] pin_raw, pin_s;
  logic rst_n_prev, start_prev;
  logic rst_rise, start_rise, pins_ok;
  logic exit_load, conv_load, exit_expired, conv_expired;
  logic [LEN_W-1:0] conv_ld_val;
  ctrl_state_e state_q, state_d;

  assign pin_raw[PIN_RSTN]  = dev_rst_n;
  assign pin_raw[PIN_START] = conv_start;
  assign pin_raw[PIN_CSN]   = cs_n;
  assign pin_raw[PIN_SCLK]  = sclk;

  adc_bit_sync #(.N(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST_VAL)) sync_i (
    .clk(clk), .rst(rst), .d_async(pin_raw), .q_sync(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_prev <= 1'b0;
      start_prev <= 1'b0;
    end else begin
      rst_n_prev <= pin_s[PIN_RSTN];
      start_prev <= pin_s[PIN_START];
    end
  end

  assign rst_rise   = pin_s[PIN_RSTN] & ~rst_n_prev;
  assign start_rise = pin_s[PIN_START] & ~start_prev;
  assign pins_ok    = ~pin_s[PIN_START] & pin_s[PIN_CSN] & ~pin_s[PIN_SCLK];

  assign conv_ld_val = LEN_W'(clamp_len(int'(conv_len), CONV_MIN, CONV_MAX) - 1);

  adc_seq_fsm fsm_i (
    .clk(clk), .rst(rst),
    .rst_n_s(pin_s[PIN_RSTN]), .rst_rise(rst_rise), .start_rise(start_rise),
    .pins_ok(pins_ok), .exit_expired(exit_expired), .conv_expired(conv_expired),
    .state_q(state_q), .state_d(state_d),
    .exit_load(exit_load), .conv_load(conv_load)
  );

  adc_down_timer #(.W(EXIT_W)) exit_tmr_i (
    .clk(clk), .rst(rst), .load(exit_load), .load_val(EXIT_LOAD), .expired(exit_expired)
  );

  adc_down_timer #(.W(LEN_W)) conv_tmr_i (
    .clk(clk), .rst(rst), .load(conv_load), .load_val(conv_ld_val), .expired(conv_expired)
  );

  // Registered outputs, all derived from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy         <= 1'b0;
      conv_busy_n <= 1'b0;
      conv_done   <= 1'b0;
      ctrl_state  <= ST_RST;
      sample_out  <= '0;
    end else begin
      conv_busy_n <= (state_d == ST_ACQ);
      rdy         <= (state_d == ST_ACQ) & pin_s[PIN_CSN];
      conv_done   <= (state_q == ST_CONV) && (state_d == ST_ACQ);
      ctrl_state  <= state_d;
      if ((state_q == ST_CONV) && (state_d == ST_ACQ)) sample_out <= sample_in;
    end
  end

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int CONV_MIN = 60,
  parameter int CONV_MAX = 68
) (
  input logic       clk,
  input logic       rst,
  input logic       rdy,
  input logic       conv_busy_n,
  input logic       conv_done,
  input logic [1:0] ctrl_state
);

  localparam int CW = $clog2(CONV_MAX + 2);
  logic [CW-1:0] conv_cnt;

  always_ff @(posedge clk) begin
    if (rst) conv_cnt <= '0;
    else if (ctrl_state != 2'b10) conv_cnt <= '0;
    else if (conv_cnt != '1) conv_cnt <= conv_cnt + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_state == 2'b00) |-> (!rdy && !conv_busy_n && !conv_done));

  p_conv_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_state == 2'b10 && $past(ctrl_state) != 2'b10) |-> ($past(ctrl_state) == 2'b01));

  p_len_window_r5: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> (conv_cnt >= CW'(CONV_MIN) && conv_cnt <= CW'(CONV_MAX)));

  p_busy_in_conv_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_state == 2'b10) |-> !conv_busy_n);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done);

  p_rdy_idle_r8: assert property (@(posedge clk) disable iff (rst)
    rdy |-> conv_busy_n);

  p_code_legal_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl_state != 2'b11);

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.CONV_MIN(CONV_MIN), .CONV_MAX(CONV_MAX)) chk_i (
  .clk(clk), .rst(rst), .rdy(rdy), .conv_busy_n(conv_busy_n),
  .conv_done(conv_done), .ctrl_state(ctrl_state)
);

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb_top;

  localparam int DATA_W   = 18;
  localparam int CONV_MIN = 60;
  localparam int CONV_MAX = 68;
  localparam int EXIT_CYC = 20;
  localparam int LEN_W    = $clog2(CONV_MAX + 1);
  localparam int NVEC     = 5;
  // stimulus: requested length, result word; expected busy-low length
  localparam int VEC_LEN [NVEC] = '{64, 10, 100, 60, 68};
  localparam int VEC_DAT [NVEC] = '{'h2A5A5, 'h00001, 'h3FFFF, 'h15555, 'h0F0F0};
  localparam int VEC_EXP [NVEC] = '{64, 60, 68, 60, 68};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [LEN_W-1:0] conv_len = LEN_W'(64);
  logic [DATA_W-1:0] sample_in = '0;
  logic rdy, conv_busy_n, conv_done;
  logic [1:0] ctrl_state;
  logic [DATA_W-1:0] sample_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_ctrl #(.DATA_W(DATA_W), .CONV_MIN(CONV_MIN), .CONV_MAX(CONV_MAX),
                  .EXIT_CYC(EXIT_CYC)) dut_i (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .conv_start(conv_start),
    .cs_n(cs_n), .sclk(sclk), .conv_len(conv_len), .sample_in(sample_in),
    .rdy(rdy), .conv_busy_n(conv_busy_n), .conv_done(conv_done),
    .ctrl_state(ctrl_state), .sample_out(sample_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // negedges from the current one until rdy is high
  task automatic lat_to_rdy(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rdy && n < 500);
  endtask

  // start a conversion, return start latency, busy-low length, done seen at end
  task automatic run_conv(output int lat, output int len, output bit done_at_end,
                          input bit inject);
    lat = 0;
    conv_start = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 2) conv_start = 1'b0;
    end while (conv_busy_n && lat < 500);
    conv_start = 1'b0;
    len = 0;
    while (!conv_busy_n && len < 500) begin
      len++;
      if (inject) begin
        if (len == 10 || len == 20 || len == 30) conv_start = 1'b1;
        if (len == 13 || len == 23 || len == 33) conv_start = 1'b0;
      end
      @(negedge clk);
    end
    done_at_end = conv_done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, lat, len;
    bit dn;
    logic [DATA_W-1:0] prev;

    cycles(4);
    // R11: fabric reset state
    chk(ctrl_state == 2'b00 && !rdy && !conv_busy_n && !conv_done && sample_out == '0,
        "R11 reset outputs", int'(ctrl_state), 0);
    rst = 1'b0;
    cycles(5);
    // R1: device reset held low
    chk(ctrl_state == 2'b00 && !rdy && !conv_busy_n, "R1 held reset", int'(rdy), 0);

    // R2: clean release
    dev_rst_n = 1'b1;
    lat_to_rdy(n);
    chk(n == EXIT_CYC + 3, "R2 exit latency", n, EXIT_CYC + 3);
    chk(ctrl_state == 2'b01 && conv_busy_n, "R10 acquisition code", int'(ctrl_state), 1);

    // Vector table: R4, R5, R7, R10
    for (int v = 0; v < NVEC; v++) begin
      conv_len  = LEN_W'(VEC_LEN[v]);
      sample_in = DATA_W'(VEC_DAT[v]);
      cycles(5);
      run_conv(lat, len, dn, 1'b0);
      chk(lat == 3, "R4 start latency", lat, 3);
      chk(len == VEC_EXP[v], "R5 conversion length", len, VEC_EXP[v]);
      chk(dn == 1'b1, "R7 done pulse at end", int'(dn), 1);
      chk(sample_out == DATA_W'(VEC_DAT[v]), "R7 captured word", int'(sample_out), VEC_DAT[v]);
      @(negedge clk);
      chk(!conv_done, "R7 done one cycle", int'(conv_done), 0);
    end

    // R6: start edges during conversion ignored
    conv_len  = LEN_W'(64);
    sample_in = DATA_W'('h1234);
    cycles(5);
    run_conv(lat, len, dn, 1'b1);
    chk(len == 64, "R6 length unchanged", len, 64);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!conv_busy_n) n++;
    end
    chk(n == 0, "R6 no follow-up conversion", n, 0);

    // R8: chip select gates rdy
    cs_n = 1'b0;
    cycles(3);
    chk(!rdy && conv_busy_n, "R8 rdy low with cs_n low", int'(rdy), 0);
    cs_n = 1'b1;
    cycles(3);
    chk(rdy == conv_busy_n && rdy, "R8 rdy follows status", int'(rdy), 1);

    // R9: reset during conversion aborts
    prev = sample_out;
    sample_in = DATA_W'('h3C3C3);
    conv_start = 1'b1;
    cycles(2);
    conv_start = 1'b0;
    cycles(20);
    n = 0;
    dev_rst_n = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (conv_done) n++;
    end
    chk(n == 0, "R9 no done on abort", n, 0);
    chk(ctrl_state == 2'b00 && !rdy && !conv_busy_n, "R9 abort to reset", int'(ctrl_state), 0);
    chk(sample_out == prev, "R9 result kept", int'(sample_out), int'(prev));

    // R3: release with chip select low
    cs_n = 1'b0;
    cycles(2);
    dev_rst_n = 1'b1;
    cycles(EXIT_CYC + 10);
    chk(ctrl_state == 2'b00 && !conv_busy_n, "R3 stuck with cs_n low", int'(ctrl_state), 0);
    cs_n = 1'b1;
    cycles(EXIT_CYC + 10);
    chk(ctrl_state == 2'b00 && !rdy, "R3 late pin fix ignored", int'(ctrl_state), 0);
    dev_rst_n = 1'b0;
    cycles(4);
    dev_rst_n = 1'b1;
    lat_to_rdy(n);
    chk(n == EXIT_CYC + 3, "R2 exit after repulse", n, EXIT_CYC + 3);

    // R3: release with serial clock high
    dev_rst_n = 1'b0;
    sclk = 1'b1;
    cycles(4);
    dev_rst_n = 1'b1;
    cycles(EXIT_CYC + 10);
    chk(ctrl_state == 2'b00 && !rdy, "R3 stuck with sclk high", int'(ctrl_state), 0);
    sclk = 1'b0;
    dev_rst_n = 1'b0;
    cycles(4);
    dev_rst_n = 1'b1;
    lat_to_rdy(n);
    chk(n == EXIT_CYC + 3 && ctrl_state == 2'b01, "R2 exit after sclk fix", n, EXIT_CYC + 3);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule